// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider with Phase Offset

This block divides a reference clock through two cascaded counter stages. Each stage has its own high-time count, low-time count, 4-bit phase offset and start-high flag, so it can produce even or odd ratios and hold off its first output pulse by a programmed number of its own input periods. The second stage advances once per period of the first stage's output, so ratios and delays multiply through the chain.

All logic runs on the reference clock. A stage's "input clock" is carried as a one-cycle advance strobe, which marks the start of each high phase of the stage before it. A synchronous sync pulse reloads every counter from the phase settings and captures the configuration. Several instances can therefore be realigned to each other in a deterministic way. Each stage can be bypassed, and when both are bypassed the reference clock itself appears at the output.

Top module: `cdiv_cascade`

## Requirements
- R1: A stage with high field N and low field M repeats a pattern of N+1 input periods high followed by M+1 input periods low, which gives a ratio of N+M+2.
- R2: N equal to M gives an even ratio with 50% duty. M = N+1 gives an odd ratio whose high phase is one input period shorter than its low phase.
- R3: With start-high clear, the phase value is the 4-bit offset P. After sync is released, the stage's output stays low for P input periods. Its first high phase begins on input period P+1, so a lone first stage rises at reference edge P+1, counting the first edge that samples sync low as edge 1.
- R4: With start-high set, the phase value is 16+P and the hold-off becomes P+M+1 input periods. During the hold-off the output stays high, and it then continues straight into a full N+1 high phase.
- R5: While sync is asserted, from the edge after the first sync onward, the output equals the start-high bit of the last non-bypassed stage.
- R6: Stage 2 advances once per high-phase start of stage 1, and it acts on the reference edge after that start. With both stages active, with D1 and D2 the stage hold-offs and T1 = N1+M1+2, the output first goes high at edge D1+D2·T1+2. It then stays high (N2+1)·T1 edges and low (M2+1)·T1 edges.
- R7: A bypassed stage passes its input level and advance strobe straight through. When only stage 1 is bypassed, stage 2 advances on every reference edge and rises at edge D2+1. When only stage 2 is bypassed, the output is stage 1's output.
- R8: With both stages bypassed, the output follows the reference clock level.
- R9: Changes on the configuration inputs while sync is low have no effect on the output until the next sync.
- R10: Every sync restarts the sequence, so the same configuration gives the same waveform after each sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| sync_i | input | 1 | Synchronous reset / realign; captures configuration |
| hi_cnt_i | input | STAGES*4 | High-phase count N per stage (stage 0 in low bits) |
| lo_cnt_i | input | STAGES*4 | Low-phase count M per stage |
| ofs_i | input | STAGES*4 | 4-bit phase offset per stage |
| start_hi_i | input | STAGES | Start-high flag per stage (adds 16 to phase) |
| bypass_i | input | STAGES | Divide-by-1 pass-through per stage |
| div_o | output | 1 | Divided clock output |

## Verification
A wrong hold-off counter moves the first output edge, and this shows up within the first D1+D2·T1+2 reference cycles after sync. A wrong phase counter or reload value lengthens or shortens a high or low phase, which is visible within one output period. A misrouted advance strobe between the stages scales every stage-2 interval by the wrong factor, so the bench compares the complete output waveform edge by edge over two output periods for each configuration. A broken configuration shadow shows up as a different waveform right after mid-run input changes.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  parameter int CNT_W = 4;
  localparam int DLY_W = CNT_W + 2;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] ofs;
    logic             start_hi;
    logic             bypass;
  } stage_cfg_t;

  // Hold-off in input periods: offset alone, or offset + low count + 1 when start-high.
  function automatic logic [DLY_W-1:0] start_delay(stage_cfg_t c);
    if (c.start_hi) return DLY_W'(c.ofs) + DLY_W'(c.lo) + DLY_W'(1);
    return DLY_W'(c.ofs);
  endfunction
endpackage

// File: rtl/cdiv_shadow.sv
module cdiv_shadow
  import cdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       sync_i,
  input  stage_cfg_t cfg_i,
  output stage_cfg_t cfg_o
);
  logic armed_q;

  always_ff @(posedge clk_i) begin
    if (sync_i) begin
      armed_q <= 1'b1;
      cfg_o   <= cfg_i;
    end
  end

  // R9
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (sync_i || !armed_q)
    1'b1 |=> $stable(cfg_o));
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
  import cdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       sync_i,
  input  stage_cfg_t cfg_i,
  input  logic       adv_i,
  input  logic       lvl_i,
  output logic       lvl_o,
  output logic       rise_o,
  output logic       act_o
);
  stage_cfg_t       cfg_q;
  logic             armed_q;
  logic             run_q;
  logic             lvl_q;
  logic             rise_q;
  logic [DLY_W-1:0] wait_q;
  logic [CNT_W-1:0] cnt_q;

  cdiv_shadow u_shadow (
    .clk_i  (clk_i),
    .sync_i (sync_i),
    .cfg_i  (cfg_i),
    .cfg_o  (cfg_q)
  );

  // Named internal events
  logic wait_done;
  logic phase_done;
  assign wait_done  = adv_i & ~run_q & (wait_q == '0);
  assign phase_done = adv_i &  run_q & (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (sync_i) begin
      armed_q <= 1'b1;
      run_q   <= 1'b0;
      wait_q  <= start_delay(cfg_i);
      cnt_q   <= '0;
      lvl_q   <= cfg_i.start_hi;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (wait_done) begin
        run_q  <= 1'b1;
        lvl_q  <= 1'b1;
        cnt_q  <= cfg_q.hi;
        rise_q <= 1'b1;
      end else if (phase_done) begin
        lvl_q  <= ~lvl_q;
        cnt_q  <= lvl_q ? cfg_q.lo : cfg_q.hi;
        rise_q <= ~lvl_q;
      end else if (adv_i && run_q) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (adv_i) begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign lvl_o  = cfg_q.bypass ? lvl_i : lvl_q;
  assign rise_o = cfg_q.bypass ? adv_i : rise_q;
  assign act_o  = ~cfg_q.bypass;

  // R5
  sync_level_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    $past(sync_i) |-> (lvl_q == $past(cfg_i.start_hi)));

  // R4
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (sync_i || !armed_q)
    (!run_q && !wait_done) |=> $stable(lvl_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (sync_i || !armed_q)
    !adv_i |=> $stable(lvl_q));

  // R1
  rise_high_chk: assert property (@(posedge clk_i) disable iff (sync_i || !armed_q)
    rise_q |-> lvl_q);
endmodule

// File: rtl/cdiv_cascade.sv
module cdiv_cascade
  import cdiv_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      sync_i,
  input  logic [STAGES*CNT_W-1:0]   hi_cnt_i,
  input  logic [STAGES*CNT_W-1:0]   lo_cnt_i,
  input  logic [STAGES*CNT_W-1:0]   ofs_i,
  input  logic [STAGES-1:0]         start_hi_i,
  input  logic [STAGES-1:0]         bypass_i,
  output logic                      div_o
);
  logic [STAGES:0]   lvl_c;
  logic [STAGES:0]   adv_c;
  logic [STAGES-1:0] act_c;
  logic              armed_q;

  assign lvl_c[0] = clk_i;
  assign adv_c[0] = 1'b1;

  always_ff @(posedge clk_i) begin
    if (sync_i) armed_q <= 1'b1;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    stage_cfg_t cfg;
    assign cfg.hi       = hi_cnt_i[g*CNT_W +: CNT_W];
    assign cfg.lo       = lo_cnt_i[g*CNT_W +: CNT_W];
    assign cfg.ofs      = ofs_i[g*CNT_W +: CNT_W];
    assign cfg.start_hi = start_hi_i[g];
    assign cfg.bypass   = bypass_i[g];

    cdiv_stage u_stage (
      .clk_i  (clk_i),
      .sync_i (sync_i),
      .cfg_i  (cfg),
      .adv_i  (adv_c[g]),
      .lvl_i  (lvl_c[g]),
      .lvl_o  (lvl_c[g+1]),
      .rise_o (adv_c[g+1]),
      .act_o  (act_c[g])
    );

    // R6
    strobe_level_chk: assert property (@(posedge clk_i) disable iff (sync_i || !armed_q)
      (act_c[g] && adv_c[g+1]) |-> lvl_c[g+1]);
  end

  assign div_o = lvl_c[STAGES];
endmodule

// File: tb/cdiv_cascade_test.sv
module cdiv_cascade_test;
  logic       clk = 1'b0;
  logic       sync;
  logic [7:0] hi, lo, ofs;
  logic [1:0] sh, by;
  logic       dout;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  always #2 clk = ~clk;

  cdiv_cascade #(.STAGES(2)) uut (
    .clk_i(clk), .sync_i(sync), .hi_cnt_i(hi), .lo_cnt_i(lo), .ofs_i(ofs),
    .start_hi_i(sh), .bypass_i(by), .div_o(dout)
  );

  // Vector: n1 m1 po1 sh1 by1 | n2 m2 po2 sh2 by2
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 4'd1, 4'd0,  1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R1 R2 even
    {4'd2, 4'd3, 4'd0,  1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R1 R2 odd
    {4'd0, 4'd0, 4'd5,  1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R3
    {4'd3, 4'd2, 4'd15, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R3 max offset
    {4'd2, 4'd4, 4'd0,  1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R4 phase 16
    {4'd1, 4'd5, 4'd9,  1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R4
    {4'd15,4'd15,4'd15, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1}, // R4 phase 31
    {4'd0, 4'd0, 4'd0,  1'b0, 1'b1, 4'd2, 4'd1, 4'd3, 1'b0, 1'b0}, // R7
    {4'd1, 4'd1, 4'd0,  1'b0, 1'b0, 4'd1, 4'd2, 4'd2, 1'b0, 1'b0}, // R6
    {4'd0, 4'd1, 4'd3,  1'b0, 1'b0, 4'd0, 4'd0, 4'd1, 1'b1, 1'b0}, // R6 R4
    {4'd2, 4'd2, 4'd2,  1'b1, 1'b0, 4'd3, 4'd3, 4'd4, 1'b0, 1'b0}, // R6
    {4'd0, 4'd0, 4'd0,  1'b0, 1'b1, 4'd4, 4'd4, 4'd0, 1'b1, 1'b0}  // R7 R4
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:    return "R1/R2";
      2, 3:    return "R3";
      4, 5, 6: return "R4";
      7, 11:   return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic int hold_off(int n_off, int start_hi, int m);
    int phase = 16 * start_hi + n_off;
    if (phase < 16) return phase;
    return phase - 16 + m + 1;
  endfunction

  task automatic drive(logic [27:0] v);
    hi  = {v[13:10], v[27:24]};
    lo  = {v[9:6],   v[23:20]};
    ofs = {v[5:2],   v[19:16]};
    sh  = {v[1],     v[15]};
    by  = {v[0],     v[14]};
  endtask

  task automatic run_case(int idx, logic [27:0] v, logic [27:0] alt, bit swap, string tag);
    int n1 = int'(v[27:24]), m1 = int'(v[23:20]), n2 = int'(v[13:10]), m2 = int'(v[9:6]);
    int d1 = hold_off(int'(v[19:16]), int'(v[15]), m1);
    int d2 = hold_off(int'(v[5:2]),   int'(v[1]),  m2);
    int e, h, l, t1, bad_k;
    logic init, expv, bad_v;
    bit bad;
    if (v[0]) begin
      e = d1 + 1; h = n1 + 1; l = m1 + 1; init = v[15];
    end else if (v[14]) begin
      e = d2 + 1; h = n2 + 1; l = m2 + 1; init = v[1];
    end else begin
      t1 = n1 + m1 + 2;
      e = d1 + d2 * t1 + 2; h = (n2 + 1) * t1; l = (m2 + 1) * t1; init = v[1];
    end
    drive(v);
    sync = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    checks++;
    if (dout !== init) begin
      fails++;
      $display("FAIL R5 vec %0d: level during sync %b expected %b", idx, dout, init);
    end
    sync = 1'b0;
    if (swap) drive(alt);
    bad = 0; bad_k = 0; bad_v = 0; expv = 0;
    for (int k = 1; k <= e + 2 * (h + l); k++) begin
      @(posedge clk); #1;
      expv = (k < e) ? init : (((k - e) % (h + l)) < h);
      if (!bad && dout !== expv) begin bad = 1; bad_k = k; bad_v = dout; end
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s vec %0d edge %0d: dout=%b expected %b", tag, idx, bad_k, bad_v, ~bad_v);
    end
  endtask

  initial begin
    sync = 1'b1;
    drive(VEC[0]);
    repeat (3) @(posedge clk);
    #1;
    // Table walk: R1 R2 R3 R4 R6 R7, each also re-syncs (R10)
    for (int i = 0; i < NV; i++) run_case(i, VEC[i], VEC[i], 1'b0, tag_of(i));
    // R9: change every field mid-run, waveform must stay that of the synced config
    run_case(100, VEC[8], VEC[6], 1'b1, "R9");
    // R10: re-sync with same config reproduces the same waveform
    run_case(101, VEC[10], VEC[10], 1'b0, "R10");
    run_case(102, VEC[10], VEC[10], 1'b0, "R10");
    // R8: both stages bypassed, output follows the reference clock
    drive({4'd3, 4'd3, 4'd0, 1'b0, 1'b1, 4'd3, 4'd3, 4'd0, 1'b0, 1'b1});
    sync = 1'b1;
    @(posedge clk); #1;
    sync = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      checks++;
      if (dout !== 1'b1) begin
        fails++;
        $display("FAIL R8 high half: dout=%b expected 1", dout);
      end
      @(negedge clk); #1;
      checks++;
      if (dout !== 1'b0) begin
        fails++;
        $display("FAIL R8 low half: dout=%b expected 0", dout);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule